// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Control

This block compares a divided oscillator strobe with a reference strobe and raises pump-up or pump-down requests that drive an external charge pump. It uses memory: a strobe sets its request flag, and the flag stays set until the opposite strobe arrives. While the loop is far from lock, the flags therefore carry frequency information as well as phase. This pulls the loop in quickly. All strobes are single-cycle pulses that are synchronous to the block clock.

A second, always-running copy of the same flag pair measures the phase error. Each cycle in which exactly one of its flags is set counts as one unit of error. On each slow strobe from the sample-and-hold path, the accumulated error is compared with a window, and the counter is then restarted. A run of small errors steps a saturating lock counter up to a target. When the counter reaches the target, the lock flag goes high. One oversized error clears the counter and drops the lock flag. A two-bit mode input sets how the pump outputs are gated. The detector can be left under automatic control, where it is switched off while locked, or it can be forced on or forced off. The slow strobe is normally 32 times less frequent than the comparison strobes, but the block does not enforce this ratio.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: Asynchronous active-low reset clears both pump flags, the error meter and the lock counter: `pump_up`, `pump_dn` and `in_lock` read 0, and `det_active` reads 1 in automatic mode.
- R2: While the detector is active, a cycle with `ref_stb` high makes `pump_up` high after the next clock edge, and a cycle with `vco_stb` high does the same for `pump_dn`.
- R3: When both pump flags are set, both clear at the next clock edge. A strobe arriving in that same cycle still sets its own flag.
- R4: Memory: a set flag stays set through further strobes of the same kind until the opposite strobe arrives.
- R5: The error meter counts the cycles in which exactly one of its flags is set, saturating at 2^ERR_W-1. On a `hold_stb` cycle an error of at most ERR_WINDOW (default 3) counts as small, and the meter restarts from 0.
- R6: A `hold_stb` that finds an error above ERR_WINDOW clears the lock counter, so `in_lock` reads 0 after that edge.
- R7: `in_lock` is 1 exactly when the lock counter equals LOCK_TARGET (default 4), and it changes only at edges that close a `hold_stb` cycle.
- R8: Mode `pd_mode` = 2'b00 or 2'b01 gives automatic control (`det_active` = not `in_lock`), 2'b10 forces the detector on, and 2'b11 forces it off.
- R9: While `det_active` is 0, `pump_up` and `pump_dn` read 0 in that same cycle and both flags are cleared at the next edge. After the detector is re-enabled, no stale request appears.
- R10: The error meter and the lock counter keep working while the detector is gated off, so a locked loop that drifts out of the window loses lock.
- R11: The lock counter steps by one per small-error evaluation and saturates at LOCK_TARGET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | 1 | Reference comparison strobe, one cycle wide |
| vco_stb | input | 1 | Divided oscillator strobe, one cycle wide |
| hold_stb | input | 1 | Slow sample-and-hold strobe that triggers lock evaluation |
| pd_mode | input | 2 | Detector mode: 0x automatic, 10 forced on, 11 forced off |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| det_active | output | 1 | Digital detector currently enabled |
| in_lock | output | 1 | 1 when lock is qualified, 0 when out of lock |

## Verification
The assertions assume that every strobe input is a synchronous level sampled at the clock edge and that `pd_mode` is valid in every cycle. They do not assume any ratio between `hold_stb` and the comparison strobes, nor any spacing between `ref_stb` and `vco_stb`. The stimulus drives all inputs half a cycle away from the active edge and holds each strobe high for exactly one cycle. It places `hold_stb` between strobe pairs at chosen distances, so that errors land just inside and just outside the window. It also switches the mode while the loop is both locked and unlocked.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO_A    = 2'b00,
    MODE_AUTO_B    = 2'b01,
    MODE_FORCE_ON  = 2'b10,
    MODE_FORCE_OFF = 2'b11
  } det_mode_e;

  // Detector enable as a function of the mode field and the lock state.
  function automatic logic det_enable(input logic [1:0] mode, input logic locked);
    logic en;
    if (!mode[1]) en = !locked;
    else          en = !mode[0];
    return en;
  endfunction

  // Next value of one memory flag: cleared by the pair reset, set by its strobe.
  function automatic logic flag_next(input logic cur, input logic pair_clr, input logic stb);
    return (cur & ~pair_clr) | stb;
  endfunction

  // Error accepted when it lies inside the window (inclusive).
  function automatic logic err_in_window(input int unsigned err, input int unsigned win);
    return err <= win;
  endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic lead_stb,
  input  logic lag_stb,
  output logic lead_q,
  output logic lag_q,
  output logic pair_clr
);
  import pfd_lock_pkg::*;

  assign pair_clr = lead_q & lag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q <= 1'b0;
      lag_q  <= 1'b0;
    end else if (!enable) begin
      lead_q <= 1'b0;
      lag_q  <= 1'b0;
    end else begin
      lead_q <= flag_next(lead_q, pair_clr, lead_stb);
      lag_q  <= flag_next(lag_q, pair_clr, lag_stb);
    end
  end

endmodule

// File: rtl/pfd_err_meter.sv
module pfd_err_meter #(
  parameter int unsigned ERR_W      = 6,
  parameter int unsigned ERR_WINDOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_stb,
  input  logic vco_stb,
  input  logic hold_stb,
  output logic eval_evt,
  output logic eval_small
);
  import pfd_lock_pkg::*;

  localparam logic [ERR_W-1:0] ACC_MAX = '1;
  localparam int unsigned PAD_W = 32 - ERR_W;

  logic             m_ref_q;
  logic             m_vco_q;
  logic             m_clr;
  logic             one_side;
  logic [ERR_W-1:0] err_acc;

  // Always-enabled copy of the flag pair used purely for measurement.
  pfd_core u_meter_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (1'b1),
    .lead_stb (ref_stb),
    .lag_stb  (vco_stb),
    .lead_q   (m_ref_q),
    .lag_q    (m_vco_q),
    .pair_clr (m_clr)
  );

  assign one_side   = m_ref_q ^ m_vco_q;
  assign eval_evt   = hold_stb;
  assign eval_small = hold_stb & err_in_window({{PAD_W{1'b0}}, err_acc}, ERR_WINDOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_acc <= '0;
    end else if (hold_stb) begin
      err_acc <= '0;
    end else if (one_side && (err_acc != ACC_MAX)) begin
      err_acc <= err_acc + 1'b1;
    end
  end

endmodule

// File: rtl/pfd_lock_counter.sv
module pfd_lock_counter #(
  parameter int unsigned LOCK_TARGET = 4,
  parameter int unsigned CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_evt,
  input  logic             eval_small,
  output logic [CNT_W-1:0] lock_cnt,
  output logic             in_lock
);

  localparam logic [CNT_W-1:0] TGT = CNT_W'(LOCK_TARGET);

  assign in_lock = (lock_cnt == TGT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_cnt <= '0;
    end else if (eval_evt) begin
      if (!eval_small)          lock_cnt <= '0;
      else if (lock_cnt != TGT) lock_cnt <= lock_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl #(
  parameter int unsigned ERR_W       = 6,
  parameter int unsigned ERR_WINDOW  = 3,
  parameter int unsigned LOCK_TARGET = 4,
  localparam int unsigned CNT_W      = $clog2(LOCK_TARGET + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_stb,
  input  logic       vco_stb,
  input  logic       hold_stb,
  input  logic [1:0] pd_mode,
  output logic       pump_up,
  output logic       pump_dn,
  output logic       det_active,
  output logic       in_lock
);
  import pfd_lock_pkg::*;

  logic             up_q;
  logic             dn_q;
  logic             pump_clr;
  logic             eval_evt;
  logic             eval_small;
  logic [CNT_W-1:0] lock_cnt;

  assign det_active = det_enable(pd_mode, in_lock);

  pfd_core u_pump_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (det_active),
    .lead_stb (ref_stb),
    .lag_stb  (vco_stb),
    .lead_q   (up_q),
    .lag_q    (dn_q),
    .pair_clr (pump_clr)
  );

  pfd_err_meter #(
    .ERR_W      (ERR_W),
    .ERR_WINDOW (ERR_WINDOW)
  ) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_stb    (ref_stb),
    .vco_stb    (vco_stb),
    .hold_stb   (hold_stb),
    .eval_evt   (eval_evt),
    .eval_small (eval_small)
  );

  pfd_lock_counter #(
    .LOCK_TARGET (LOCK_TARGET),
    .CNT_W       (CNT_W)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval_evt   (eval_evt),
    .eval_small (eval_small),
    .lock_cnt   (lock_cnt),
    .in_lock    (in_lock)
  );

  assign pump_up = up_q & det_active;
  assign pump_dn = dn_q & det_active;

endmodule

// File: rtl/pfd_lock_checker.sv
module pfd_lock_checker #(
  parameter int unsigned LOCK_TARGET = 4,
  parameter int unsigned CNT_W       = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_stb,
  input logic             vco_stb,
  input logic             hold_stb,
  input logic             pump_up,
  input logic             pump_dn,
  input logic             det_active,
  input logic             in_lock,
  input logic             eval_small,
  input logic [CNT_W-1:0] lock_cnt
);

  a_r2_up_follows_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (det_active && ref_stb) |=> (pump_up || !det_active));

  a_r2_dn_follows_vco: assert property (@(posedge clk) disable iff (!rst_n)
    (det_active && vco_stb) |=> (pump_dn || !det_active));

  a_r3_pair_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && pump_dn && !ref_stb && !vco_stb) |=> (!pump_up && !pump_dn));

  a_r4_up_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && !pump_dn && !vco_stb) |=> (pump_up || !det_active));

  a_r6_big_error_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_stb && !eval_small) |=> !in_lock);

  a_r7_lock_only_on_eval: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_stb |=> $stable(in_lock));

  a_r9_no_stale_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_active && !ref_stb) |=> !pump_up);

  always_ff @(posedge clk) begin
    if (rst_n) begin
      a_r11_cnt_bounded: assert (lock_cnt <= CNT_W'(LOCK_TARGET));
    end
  end

endmodule

bind pfd_lock_ctrl pfd_lock_checker #(
  .LOCK_TARGET (LOCK_TARGET),
  .CNT_W       (CNT_W)
) u_pfd_lock_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_stb    (ref_stb),
  .vco_stb    (vco_stb),
  .hold_stb   (hold_stb),
  .pump_up    (pump_up),
  .pump_dn    (pump_dn),
  .det_active (det_active),
  .in_lock    (in_lock),
  .eval_small (eval_small),
  .lock_cnt   (lock_cnt)
);

// File: tb/pfd_lock_ctrl_bench.sv
module pfd_lock_ctrl_bench;

  localparam int TARGET = 4;
  localparam int WIN    = 3;
  localparam int ACCMAX = 63;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_stb = 1'b0;
  logic       vco_stb = 1'b0;
  logic       hold_stb = 1'b0;
  logic [1:0] pd_mode = 2'b00;
  logic       pump_up, pump_dn, det_active, in_lock;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  string cur_req = "R1";

  // Behavioural reference state
  bit m_up, m_dn, m_a, m_b;
  int m_acc, m_cnt;

  pfd_lock_ctrl u_pfd_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .vco_stb(vco_stb),
    .hold_stb(hold_stb), .pd_mode(pd_mode), .pump_up(pump_up),
    .pump_dn(pump_dn), .det_active(det_active), .in_lock(in_lock)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit model_enable(input logic [1:0] m);
    bit locked = (m_cnt == TARGET);
    if (m == 2'b10) return 1'b1;
    if (m == 2'b11) return 1'b0;
    return !locked;
  endfunction

  // One cycle: drive at negedge, compare mid-low-phase, advance model at posedge.
  task automatic step(input bit r, input bit v, input bit h, input logic [1:0] m);
    bit en, both, mboth, lopsided;
    ref_stb = r; vco_stb = v; hold_stb = h; pd_mode = m;
    #1;
    en = model_enable(m);
    check(cur_req, "pump_up", pump_up, en && m_up);
    check(cur_req, "pump_dn", pump_dn, en && m_dn);
    check(cur_req, "det_active", det_active, en);
    check(cur_req, "in_lock", in_lock, m_cnt == TARGET);
    @(posedge clk);
    both = m_up && m_dn;
    if (!en) begin
      m_up = 0; m_dn = 0;
    end else begin
      m_up = both ? r : (m_up || r);
      m_dn = both ? v : (m_dn || v);
    end
    lopsided = (m_a != m_b);
    mboth = m_a && m_b;
    m_a = mboth ? r : (m_a || r);
    m_b = mboth ? v : (m_b || v);
    if (h) begin
      if (m_acc <= WIN) m_cnt = (m_cnt < TARGET) ? m_cnt + 1 : TARGET;
      else              m_cnt = 0;
      m_acc = 0;
    end else if (lopsided && m_acc < ACCMAX) begin
      m_acc++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [1:0] m);
    for (int i = 0; i < n; i++) step(0, 0, 0, m);
  endtask

  // ref, then vco after gap cycles, then settle and evaluate
  task automatic pair_then_hold(input int gap, input logic [1:0] m);
    step(1, 0, 0, m);
    idle(gap - 1, m);
    step(0, 1, 0, m);
    idle(2, m);
    step(0, 0, 1, m);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_up = 0; m_dn = 0; m_a = 0; m_b = 0; m_acc = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset state visible while reset is held
    #1;
    check("R1", "pump_up", pump_up, 1'b0);
    check("R1", "in_lock", in_lock, 1'b0);
    check("R1", "det_active", det_active, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2, 2'b00);

    cur_req = "R2";            // ref leads vco
    step(1, 0, 0, 2'b00); idle(2, 2'b00); step(0, 1, 0, 2'b00); idle(3, 2'b00);
    step(0, 1, 0, 2'b00); idle(2, 2'b00); step(1, 0, 0, 2'b00); idle(3, 2'b00);

    cur_req = "R3";            // coincident strobes and strobe during clear
    step(1, 1, 0, 2'b00); idle(3, 2'b00);
    step(1, 0, 0, 2'b00); step(0, 1, 0, 2'b00); step(1, 0, 0, 2'b00); idle(3, 2'b00);

    cur_req = "R4";            // repeated ref strobes keep UP
    for (int i = 0; i < 4; i++) begin step(1, 0, 0, 2'b00); idle(1, 2'b00); end
    step(0, 1, 0, 2'b00); idle(3, 2'b00);
    step(0, 0, 1, 2'b00);      // large error here resets the counter

    cur_req = "R11";           // climb to lock
    for (int i = 0; i < TARGET; i++) pair_then_hold(1, 2'b00);
    check("R7", "in_lock after target", in_lock, 1'b1);
    check("R8", "auto mode gated off", det_active, 1'b0);
    pair_then_hold(2, 2'b01);  // further small error, saturated

    cur_req = "R10";           // detector off but meter runs
    pair_then_hold(3, 2'b00);  // error 3: inside window
    check("R5", "window edge keeps lock", in_lock, 1'b1);
    pair_then_hold(4, 2'b00);  // error 4: outside
    check("R6", "oversized error drops lock", in_lock, 1'b0);
    check("R9", "re-enabled without stale UP", pump_up, 1'b0);

    cur_req = "R8";            // forced modes
    for (int i = 0; i < TARGET; i++) pair_then_hold(1, 2'b10);
    check("R8", "forced on while locked", det_active, 1'b1);
    step(1, 0, 0, 2'b10); idle(2, 2'b10);
    cur_req = "R9";
    step(0, 0, 0, 2'b11); idle(2, 2'b11); step(1, 0, 0, 2'b11);
    idle(2, 2'b10); step(0, 1, 0, 2'b10); idle(2, 2'b10);

    cur_req = "R5";            // saturating accumulator
    step(1, 0, 0, 2'b10); idle(80, 2'b10); step(0, 0, 1, 2'b10);
    check("R5", "saturated error not small", in_lock, 1'b0);
    step(0, 1, 0, 2'b10); idle(3, 2'b00);

    cur_req = "R7";
    step(0, 0, 1, 2'b00); idle(2, 2'b00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule